// File: doc/BRIEF.md
# Descriptor Chain Start Register

This block holds the 64-bit pointer that tells a descriptor-driven DMA engine in a storage host controller where its chain of descriptor address entries begins. Software writes it over a byte-enabled register bus. One byte lane acts as the trigger: when a write includes that lane, the block raises a one-cycle start pulse for the DMA engine. Which lane triggers depends on whether the controller uses 32-bit or 64-bit system addressing.

The register forces its low address bits to zero to suit the addressing mode. These are two bits in 32-bit mode and three bits in 64-bit mode. In 32-bit mode the pointer seen by the engine uses only the lower word. Each time the fetch logic consumes one descriptor address entry, it pulses an advance input. The register then moves forward by one entry, with a step that depends on the mode and is set by a parameter. Descriptor parsing, bus-master fetching and data movement are handled elsewhere.

Top module: `dchain_ptr_reg`

## Requirements
- R1: While `rst_n` is low, `rd_data`, `ptr` and `start` are all zero, whatever is driven on the inputs. The reset is asynchronous.
- R2: A write with `wr_en` high changes only the bytes whose `wr_be` bit is set. Byte i is `wr_data[8i+7:8i]`. The new value appears on `rd_data` after the next rising clock edge.
- R3: When `mode64` is 0, bits [1:0] of `rd_data` and `ptr` read 0 and `ptr[63:32]` reads 0. `rd_data[63:32]` shows the stored upper word.
- R4: When `mode64` is 1, bits [2:0] of `rd_data` and `ptr` read 0, and `ptr` equals `rd_data` across all 64 bits.
- R5: When `mode64` is 0, a write with `wr_be[3]` set makes `start` go high for the following cycle. A write that enables only other lanes, lane 7 included, leaves `start` low.
- R6: When `mode64` is 1, only a write with `wr_be[7]` set makes `start` go high for the following cycle. A write to lane 3 alone leaves `start` low.
- R7: Each triggering write gives a pulse of exactly one cycle. In that cycle `ptr` already shows the value that the write produced. Triggering writes on back-to-back cycles give `start` high on both of the following cycles.
- R8: When `mode64` is 0, a `fetch_adv` with no write sets the lower word to its aligned value plus STEP32 (default 8), wrapping modulo 2^32. The upper stored word stays unchanged.
- R9: When `mode64` is 1, a `fetch_adv` with no write sets the register to its aligned value plus STEP64 (default 16), wrapping modulo 2^64.
- R10: When `wr_en` and `fetch_adv` are high in the same cycle, the write is applied and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64 | input | 1 | Addressing mode: 1 selects 64-bit, 0 selects 32-bit |
| wr_en | input | 1 | Register bus write strobe for this register |
| wr_be | input | 8 | Byte enables; bit i covers wr_data[8i+7:8i] |
| wr_data | input | 64 | Write data |
| fetch_adv | input | 1 | One-cycle pulse per descriptor address entry consumed |
| ptr | output | 64 | Aligned pointer presented to the DMA engine |
| start | output | 1 | One-cycle transfer start pulse |
| rd_data | output | 64 | Readback value with alignment bits masked |

## Verification
The hardest case to reach from the ports is a collision: a bus write and a fetch advance land in the same cycle. The write must win even when it touches only a low lane that cannot trigger a start. The stimulus table first parks the pointer at a 64-bit-aligned value. It then drives a lane-0 write together with `fetch_adv`, and checks that the stored low bits are the written ones and that the step was not added. Other rows cover lane writes made under the opposite mode from the one that triggers, and advances that wrap around the 32-bit and the 64-bit boundaries. Directed tests pull the asynchronous reset low in the middle of a triggering write.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
   localparam int BYTE_W = 8;
   localparam int LO_W = 32;
   localparam int ALIGN_LO32 = 2;
   localparam int ALIGN_LO64 = 3;

   // Clears the alignment bits that the active addressing mode ignores.
   function automatic logic [63:0] align_ptr(input logic [63:0] v, input logic m64);
      logic [63:0] r;
      r = v;
      r[ALIGN_LO32-1:0] = '0;
      if (m64) r[ALIGN_LO64-1:0] = '0;
      return r;
   endfunction
endpackage

// File: rtl/dchain_lane_merge.sv
module dchain_lane_merge #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]   cur,
   input  logic [DATA_W/8-1:0] be,
   input  logic [DATA_W-1:0]   wdat,
   output logic [DATA_W-1:0]   merged,
   output logic [DATA_W-1:0]   be_bits
);
   localparam int NLANE = DATA_W / dchain_pkg::BYTE_W;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign merged[g*8 +: 8]  = be[g] ? wdat[g*8 +: 8] : cur[g*8 +: 8];
      assign be_bits[g*8 +: 8] = {8{be[g]}};
   end
endmodule

// File: rtl/dchain_step_unit.sv
module dchain_step_unit #(
   parameter int DATA_W = 64,
   parameter int STEP32 = 8,
   parameter int STEP64 = 16
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [DATA_W-1:0] aligned,
   input  logic              m64,
   output logic [DATA_W-1:0] next_ptr
);
   localparam int LO_W = dchain_pkg::LO_W;
   localparam int HI_W = DATA_W - LO_W;
   localparam logic [LO_W-1:0]   INC_LO = LO_W'(STEP32);
   localparam logic [DATA_W-1:0] INC_FULL = DATA_W'(STEP64);

   logic [LO_W-1:0]   lo_sum;
   logic [DATA_W-1:0] full_sum;

   assign lo_sum   = aligned[LO_W-1:0] + INC_LO;
   assign full_sum = aligned + INC_FULL;

   if (HI_W > 0) begin : g_split
      assign next_ptr = m64 ? full_sum : {raw[DATA_W-1:LO_W], lo_sum};
   end else begin : g_flat
      assign next_ptr = m64 ? full_sum : lo_sum;
   end
endmodule

// File: rtl/dchain_start_gen.sv
module dchain_start_gen #(
   parameter int DATA_W = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                m64,
   input  logic                wr_en,
   input  logic [DATA_W/8-1:0] be,
   output logic                start
);
   localparam int LANE32 = dchain_pkg::LO_W / dchain_pkg::BYTE_W - 1;
   localparam int LANE64 = DATA_W / dchain_pkg::BYTE_W - 1;

   logic trig;
   assign trig = wr_en & (m64 ? be[LANE64] : be[LANE32]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start <= 1'b0;
      else        start <= trig;
   end

   // R5: a pulse in 32-bit mode must come from a write that included lane 3
   p_start_lane32_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !$past(m64)) |-> $past(wr_en && be[LANE32]));
   // R6: a pulse in 64-bit mode must come from a write that included the top lane
   p_start_lane64_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && $past(m64)) |-> $past(wr_en && be[LANE64]));
endmodule

// File: rtl/dchain_ptr_reg.sv
module dchain_ptr_reg #(
   parameter int DATA_W = 64,
   parameter int STEP32 = 8,
   parameter int STEP64 = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mode64,
   input  logic                wr_en,
   input  logic [DATA_W/8-1:0] wr_be,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                fetch_adv,
   output logic [DATA_W-1:0]   ptr,
   output logic                start,
   output logic [DATA_W-1:0]   rd_data
);
   localparam int LO_W = dchain_pkg::LO_W;

   if (DATA_W != 64) begin : g_bad_width
      $error("dchain_ptr_reg: DATA_W must be 64");
   end
   if (STEP32 <= 0 || (STEP32 % 4) != 0) begin : g_bad_step32
      $error("dchain_ptr_reg: STEP32 must be a positive multiple of 4");
   end
   if (STEP64 <= 0 || (STEP64 % 8) != 0) begin : g_bad_step64
      $error("dchain_ptr_reg: STEP64 must be a positive multiple of 8");
   end

   logic [DATA_W-1:0] raw_q;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] be_bits;
   logic [DATA_W-1:0] adv_val;

   dchain_lane_merge #(.DATA_W(DATA_W)) u_merge (
      .cur(raw_q), .be(wr_be), .wdat(wr_data), .merged(merged), .be_bits(be_bits)
   );

   dchain_step_unit #(.DATA_W(DATA_W), .STEP32(STEP32), .STEP64(STEP64)) u_step (
      .raw(raw_q), .aligned(rd_data), .m64(mode64), .next_ptr(adv_val)
   );

   dchain_start_gen #(.DATA_W(DATA_W)) u_start (
      .clk(clk), .rst_n(rst_n), .m64(mode64), .wr_en(wr_en), .be(wr_be), .start(start)
   );

   // Bus write outranks the fetch advance.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         raw_q <= '0;
      else if (wr_en)     raw_q <= merged;
      else if (fetch_adv) raw_q <= adv_val;
   end

   assign rd_data = dchain_pkg::align_ptr(raw_q, mode64);
   assign ptr     = mode64 ? rd_data : {{(DATA_W-LO_W){1'b0}}, rd_data[LO_W-1:0]};

   // R2: lanes without an enable keep their stored bytes across a write
   p_keep_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((raw_q ^ $past(raw_q)) & ~$past(be_bits)) == '0);
   // R8: a 32-bit advance leaves the upper stored word alone
   p_upper_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_adv && !wr_en && !mode64) |=> raw_q[DATA_W-1:LO_W] == $past(raw_q[DATA_W-1:LO_W]));
   // R9: a 64-bit advance moves the aligned pointer by one entry
   p_step64_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_adv && !wr_en && mode64) |=> raw_q == $past(rd_data) + DATA_W'(STEP64));
   // R10: on collision the enabled lanes take the written data
   p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fetch_adv) |=> ((raw_q ^ $past(wr_data)) & $past(be_bits)) == '0);
endmodule

// File: tb/dchain_ptr_reg_test.sv
module dchain_ptr_reg_test;
   typedef struct packed {
      logic        we;
      logic [7:0]  be;
      logic [63:0] wd;
      logic        adv;
      logic        m64;
      logic [63:0] ex_rd;
      logic [63:0] ex_ptr;
      logic        ex_st;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VEC [0:NVEC-1] = '{
      // R3 R5: full write in 32-bit mode, lane 3 triggers
      '{1'b1, 8'hFF, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEC, 64'h0000_0000_89AB_CDEC, 1'b1, 4'd5},
      // R7: idle cycle, pulse is gone
      '{1'b0, 8'h00, 64'h0, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEC, 64'h0000_0000_89AB_CDEC, 1'b0, 4'd7},
      // R8: advance by 8 from aligned value
      '{1'b0, 8'h00, 64'h0, 1'b1, 1'b0, 64'h0123_4567_89AB_CDF4, 64'h0000_0000_89AB_CDF4, 1'b0, 4'd8},
      // R2 R5: low-word write only
      '{1'b1, 8'h0F, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b0, 64'h0123_4567_FFFF_FFFC, 64'h0000_0000_FFFF_FFFC, 1'b1, 4'd2},
      // R8: 32-bit wrap, upper word untouched
      '{1'b0, 8'h00, 64'h0, 1'b1, 1'b0, 64'h0123_4567_0000_0004, 64'h0000_0000_0000_0004, 1'b0, 4'd8},
      // R5: lane 7 in 32-bit mode does not trigger
      '{1'b1, 8'h80, 64'hAA00_0000_0000_0000, 1'b0, 1'b0, 64'hAA23_4567_0000_0004, 64'h0000_0000_0000_0004, 1'b0, 4'd5},
      // R4 R6: lane 3 in 64-bit mode does not trigger; bit 2 masked
      '{1'b1, 8'h08, 64'h0000_0000_1100_0000, 1'b0, 1'b1, 64'hAA23_4567_1100_0000, 64'hAA23_4567_1100_0000, 1'b0, 4'd6},
      // R6 R7: lane 7 in 64-bit mode triggers, pointer already updated
      '{1'b1, 8'h80, 64'h5500_0000_0000_0000, 1'b0, 1'b1, 64'h5523_4567_1100_0000, 64'h5523_4567_1100_0000, 1'b1, 4'd6},
      // R9: advance by 16
      '{1'b0, 8'h00, 64'h0, 1'b1, 1'b1, 64'h5523_4567_1100_0010, 64'h5523_4567_1100_0010, 1'b0, 4'd9},
      // R10: write and advance collide, write wins
      '{1'b1, 8'h01, 64'h0000_0000_0000_0007, 1'b1, 1'b1, 64'h5523_4567_1100_0000, 64'h5523_4567_1100_0000, 1'b0, 4'd10},
      // R4: all ones in 64-bit mode
      '{1'b1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1, 4'd4},
      // R9: 64-bit wrap
      '{1'b0, 8'h00, 64'h0, 1'b1, 1'b1, 64'h0000_0000_0000_0008, 64'h0000_0000_0000_0008, 1'b0, 4'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode64 = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_be = '0;
   logic [63:0] wr_data = '0;
   logic        fetch_adv = 1'b0;
   logic [63:0] ptr;
   logic        start;
   logic [63:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dchain_ptr_reg uut (
      .clk(clk), .rst_n(rst_n), .mode64(mode64), .wr_en(wr_en), .wr_be(wr_be),
      .wr_data(wr_data), .fetch_adv(fetch_adv), .ptr(ptr), .start(start), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic we, input logic [7:0] be, input logic [63:0] wd,
                        input logic adv, input logic m64);
      wr_en = we; wr_be = be; wr_data = wd; fetch_adv = adv; mode64 = m64;
   endtask

   initial begin
      #3;
      // R1: outputs during reset
      chk("R1 rd in reset", rd_data, 64'h0);
      chk("R1 start in reset", {63'h0, start}, 64'h0);
      @(negedge clk);
      drive(1'b1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
      @(posedge clk); #1;
      chk("R1 start held low", {63'h0, start}, 64'h0);
      chk("R1 ptr held zero", ptr, 64'h0);
      @(negedge clk);
      drive(1'b0, 8'h00, 64'h0, 1'b0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VEC[i].we, VEC[i].be, VEC[i].wd, VEC[i].adv, VEC[i].m64);
         @(posedge clk); #1;
         chk($sformatf("R%0d vec %0d rd_data", VEC[i].req, i), rd_data, VEC[i].ex_rd);
         chk($sformatf("R%0d vec %0d ptr", VEC[i].req, i), ptr, VEC[i].ex_ptr);
         chk($sformatf("R%0d vec %0d start", VEC[i].req, i), {63'h0, start}, {63'h0, VEC[i].ex_st});
      end

      // R3: switch back to 32-bit mode, upper word hidden from ptr
      @(negedge clk);
      drive(1'b1, 8'hFF, 64'h8765_4321_0000_0107, 1'b0, 1'b0);
      @(posedge clk); #1;
      chk("R3 rd upper kept", rd_data, 64'h8765_4321_0000_0104);
      chk("R3 ptr upper zero", ptr, 64'h0000_0000_0000_0104);

      // R7: back-to-back triggering writes give two pulses, then none
      @(negedge clk);
      drive(1'b1, 8'h08, 64'h0000_0000_2200_0000, 1'b0, 1'b0);
      @(posedge clk); #1;
      chk("R7 first pulse", {63'h0, start}, 64'h1);
      @(negedge clk);
      drive(1'b1, 8'h08, 64'h0000_0000_3300_0000, 1'b0, 1'b0);
      @(posedge clk); #1;
      chk("R7 second pulse", {63'h0, start}, 64'h1);
      chk("R7 ptr with second pulse", ptr, 64'h0000_0000_3300_0104);
      @(negedge clk);
      drive(1'b0, 8'h00, 64'h0, 1'b0, 1'b0);
      @(posedge clk); #1;
      chk("R7 pulse ends", {63'h0, start}, 64'h0);

      // R1: asynchronous reset in the middle of a triggering write
      @(negedge clk);
      drive(1'b1, 8'h80, 64'hFF00_0000_0000_0000, 1'b0, 1'b1);
      #2 rst_n = 1'b0;
      #1;
      chk("R1 async clear rd", rd_data, 64'h0);
      @(posedge clk); #1;
      chk("R1 no start under reset", {63'h0, start}, 64'h0);
      @(negedge clk);
      drive(1'b0, 8'h00, 64'h0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 zero after reset", ptr, 64'h0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule